// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the architectural register state of a 32-bit core that runs in one of seven operating modes. Software always names sixteen registers, r0 to r15. Which physical copy a name reaches depends on the mode held in the low five bits of the current status word. Thirty general-purpose flops serve the fifteen names r0 to r14. The program counter is a single register that every mode shares. Five privileged exception modes also own a saved-status slot each.

The block has two combinational read ports, one write port and a dedicated program-counter port. It also has a read/write port for the current status word and a read/write port for the saved status of the current mode. An exception-entry strobe saves the current status into the target mode's slot and switches the mode on the same edge. Decode, execution, exception priority and memory access are left to the logic that surrounds the block.

Top module: `banked_regfile`

## Requirements
- R1: While `rst_n` is low and after its release, the status word reads `0x00000013`: Supervisor mode and every other bit zero. The program counter reads `PC_RESET`, which is 0 by default. Every general register and every saved-status slot reads zero.
- R2: The mode is the status word's bits [4:0]. The codes are User `10000`, fast-interrupt `10001`, IRQ `10010`, Supervisor `10011`, Abort `10111`, Undefined `11011` and System `11111`. Fast-interrupt mode has private copies of r8 to r14. IRQ, Supervisor, Abort and Undefined modes each have private r13 and r14. Every other name maps to the User copy. System mode and any code not listed use exactly the User registers.
- R3: Both read ports return, with no clock, the register that their index names in the current mode. Index 15 returns the program counter.
- R4: With `wr_en` high, `wr_data` is stored at the clock edge into the register that `wr_idx` names in the mode that was current before that edge. Index 15 writes the program counter and takes priority over the program-counter port.
- R5: `pc_out` shows the stored program counter. With `pc_wr_en` high, and no write-port access to index 15, it takes `pc_wr_data` at the edge. Otherwise it holds its value.
- R6: When a read port names the register that the write port is writing in the same cycle, the port returns the new value. This covers index 15, written through either write source.
- R7: With `stat_wr_en` high and no exception entry, the status word takes `stat_wr_data` at the edge. `stat_out` and `mode_out` show the stored word and its mode field.
- R8: In the five exception modes, `sav_rd_data` shows that mode's own saved-status slot. `sav_wr_en` writes `sav_wr_data` into that slot at the edge.
- R9: In User mode, System mode and undefined codes, `sav_rd_data` is zero and saved-status writes change nothing. `sav_err` is high in any cycle where `sav_rd_en` or `sav_wr_en` is high. `sav_err` is low in every other cycle.
- R10: At an edge where `exc_en` is high, the mode field becomes `exc_mode` and the upper status bits are kept. If `exc_mode` owns a slot, the pre-edge status word is copied into that slot. This copy takes priority over a status write and over a saved-status write to the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Read port A register name |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Read port B register name |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port register name |
| wr_data | input | DATA_W | Write port data |
| pc_wr_en | input | 1 | Program-counter port write enable |
| pc_wr_data | input | DATA_W | Program-counter port write data |
| pc_out | output | DATA_W | Stored program counter |
| stat_wr_en | input | 1 | Status word write enable |
| stat_wr_data | input | DATA_W | Status word write data |
| stat_out | output | DATA_W | Stored status word |
| mode_out | output | 5 | Current mode code |
| sav_rd_en | input | 1 | Saved-status read strobe |
| sav_wr_en | input | 1 | Saved-status write enable |
| sav_wr_data | input | DATA_W | Saved-status write data |
| sav_rd_data | output | DATA_W | Saved status of the current mode |
| sav_err | output | 1 | Saved-status access in a mode without a slot |
| exc_en | input | 1 | Exception-entry strobe |
| exc_mode | input | 5 | Target mode of the exception entry |

## Verification
The properties assume that every input carries a defined 0 or 1 after reset. They also assume that the write-first variant is selected, because the forwarding property only holds there. No assumption limits the mode codes. The properties take undefined codes as modes without a saved slot and with User registers, and the stimulus sends such a code on purpose. The properties assume nothing about how often the exception, status and saved-status strobes coincide, so the stimulus fires them together in directed cases and at random.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

   localparam int unsigned MODE_W       = 5;
   localparam int unsigned NAME_W       = 4;
   localparam int unsigned NUM_PHYS_GPR = 30;
   localparam int unsigned NUM_SAVED    = 5;
   localparam int unsigned PIDX_W       = $clog2(NUM_PHYS_GPR);
   localparam int unsigned SIDX_W       = $clog2(NUM_SAVED);
   localparam logic [NAME_W-1:0] PC_NAME = 4'd15;

   typedef enum logic [MODE_W-1:0] {
      MODE_USER   = 5'b10000,
      MODE_FAST   = 5'b10001,
      MODE_IRQ    = 5'b10010,
      MODE_SUPV   = 5'b10011,
      MODE_ABORT  = 5'b10111,
      MODE_UNDEF  = 5'b11011,
      MODE_SYSTEM = 5'b11111
   } mode_e;

   // User copies occupy 0..14, fast-interrupt r8..r14 occupy 15..21,
   // then r13/r14 pairs for IRQ, Supervisor, Abort, Undefined.
   function automatic logic [PIDX_W-1:0] phys_index(input logic [MODE_W-1:0] mode,
                                                    input logic [NAME_W-1:0] name);
      logic [PIDX_W-1:0] n;
      n = PIDX_W'(name);
      phys_index = n;
      case (mode)
         MODE_FAST:  if (name >= 4'd8)  phys_index = n + PIDX_W'(7);
         MODE_IRQ:   if (name >= 4'd13) phys_index = n + PIDX_W'(9);
         MODE_SUPV:  if (name >= 4'd13) phys_index = n + PIDX_W'(11);
         MODE_ABORT: if (name >= 4'd13) phys_index = n + PIDX_W'(13);
         MODE_UNDEF: if (name >= 4'd13) phys_index = n + PIDX_W'(15);
         default:    phys_index = n;
      endcase
   endfunction

   function automatic logic has_saved(input logic [MODE_W-1:0] mode);
      case (mode)
         MODE_FAST, MODE_IRQ, MODE_SUPV, MODE_ABORT, MODE_UNDEF: has_saved = 1'b1;
         default: has_saved = 1'b0;
      endcase
   endfunction

   function automatic logic [SIDX_W-1:0] saved_slot(input logic [MODE_W-1:0] mode);
      case (mode)
         MODE_FAST:  saved_slot = SIDX_W'(0);
         MODE_IRQ:   saved_slot = SIDX_W'(1);
         MODE_SUPV:  saved_slot = SIDX_W'(2);
         MODE_ABORT: saved_slot = SIDX_W'(3);
         MODE_UNDEF: saved_slot = SIDX_W'(4);
         default:    saved_slot = SIDX_W'(0);
      endcase
   endfunction

endpackage

// File: rtl/bankrf_port_map.sv
module bankrf_port_map
   import bankrf_pkg::*;
(
   input  logic [MODE_W-1:0] mode,
   input  logic [NAME_W-1:0] name,
   output logic [PIDX_W-1:0] pidx,
   output logic              is_pc
);
   assign pidx  = phys_index(mode, name);
   assign is_pc = (name == PC_NAME);
endmodule

// File: rtl/bankrf_gpr_array.sv
module bankrf_gpr_array
   import bankrf_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned NUM_RD      = 2,
   parameter bit          WRITE_FIRST = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we,
   input  logic [PIDX_W-1:0]                wpidx,
   input  logic [DATA_W-1:0]                wdata,
   input  logic [NUM_RD-1:0][PIDX_W-1:0]    rpidx,
   output logic [NUM_RD-1:0][DATA_W-1:0]    rdata
);
   logic [NUM_PHYS_GPR-1:0][DATA_W-1:0] cells;

   for (genvar p = 0; p < NUM_PHYS_GPR; p++) begin : g_cell
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          q <= '0;
         else if (we && wpidx == PIDX_W'(p))  q <= wdata;
      end
      assign cells[p] = q;
   end

   for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
      logic [DATA_W-1:0] stored;
      always_comb begin
         stored = '0;
         for (int p = 0; p < NUM_PHYS_GPR; p++)
            if (rpidx[r] == PIDX_W'(p)) stored = cells[p];
      end
      if (WRITE_FIRST) begin : g_fwd
         assign rdata[r] = (we && wpidx == rpidx[r]) ? wdata : stored;
      end else begin : g_plain
         assign rdata[r] = stored;
      end
   end
endmodule

// File: rtl/bankrf_status.sv
module bankrf_status
   import bankrf_pkg::*;
#(
   parameter int unsigned     DATA_W     = 32,
   parameter logic [MODE_W-1:0] RESET_MODE = MODE_SUPV
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_wr_en,
   input  logic [DATA_W-1:0] stat_wr_data,
   input  logic              sav_rd_en,
   input  logic              sav_wr_en,
   input  logic [DATA_W-1:0] sav_wr_data,
   input  logic              exc_en,
   input  logic [MODE_W-1:0] exc_mode,
   output logic [DATA_W-1:0] stat_q,
   output logic [DATA_W-1:0] sav_rd_data,
   output logic              sav_err
);
   logic [MODE_W-1:0]                mode;
   logic                             cur_has, tgt_has;
   logic [SIDX_W-1:0]                cur_slot, tgt_slot;
   logic [NUM_SAVED-1:0][DATA_W-1:0] slots;

   assign mode     = stat_q[MODE_W-1:0];
   assign cur_has  = has_saved(mode);
   assign cur_slot = saved_slot(mode);
   assign tgt_has  = has_saved(exc_mode);
   assign tgt_slot = saved_slot(exc_mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stat_q <= {{(DATA_W-MODE_W){1'b0}}, RESET_MODE};
      else if (exc_en)     stat_q <= {stat_q[DATA_W-1:MODE_W], exc_mode};
      else if (stat_wr_en) stat_q <= stat_wr_data;
   end

   for (genvar s = 0; s < NUM_SAVED; s++) begin : g_slot
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (exc_en && tgt_has && tgt_slot == SIDX_W'(s))
            q <= stat_q;
         else if (sav_wr_en && cur_has && cur_slot == SIDX_W'(s))
            q <= sav_wr_data;
      end
      assign slots[s] = q;
   end

   always_comb begin
      sav_rd_data = '0;
      for (int s = 0; s < NUM_SAVED; s++)
         if (cur_has && cur_slot == SIDX_W'(s)) sav_rd_data = slots[s];
   end

   assign sav_err = (sav_rd_en || sav_wr_en) && !cur_has;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import bankrf_pkg::*;
#(
   parameter int unsigned       DATA_W      = 32,
   parameter logic [DATA_W-1:0] PC_RESET    = '0,
   parameter bit                WRITE_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [3:0]        rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [3:0]        wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pc_wr_en,
   input  logic [DATA_W-1:0] pc_wr_data,
   output logic [DATA_W-1:0] pc_out,
   input  logic              stat_wr_en,
   input  logic [DATA_W-1:0] stat_wr_data,
   output logic [DATA_W-1:0] stat_out,
   output logic [4:0]        mode_out,
   input  logic              sav_rd_en,
   input  logic              sav_wr_en,
   input  logic [DATA_W-1:0] sav_wr_data,
   output logic [DATA_W-1:0] sav_rd_data,
   output logic              sav_err,
   input  logic              exc_en,
   input  logic [4:0]        exc_mode
);
   localparam int unsigned NUM_RD = 2;

   initial begin
      assert (DATA_W >= 8)
         else $fatal(1, "banked_regfile: DATA_W must hold the mode field and flags");
   end

   logic [DATA_W-1:0]                 stat_q;
   logic [MODE_W-1:0]                 mode;
   logic [NUM_RD-1:0][NAME_W-1:0]     rd_name;
   logic [NUM_RD-1:0][PIDX_W-1:0]     rd_pidx;
   logic [NUM_RD-1:0]                 rd_is_pc;
   logic [NUM_RD-1:0][DATA_W-1:0]     gpr_rdata;
   logic [NUM_RD-1:0][DATA_W-1:0]     port_data;
   logic [PIDX_W-1:0]                 wr_pidx;
   logic                              wr_is_pc;
   logic                              gpr_we;
   logic [DATA_W-1:0]                 pc_q, pc_next, pc_view;

   assign mode       = stat_q[MODE_W-1:0];
   assign rd_name[0] = rd_a_idx;
   assign rd_name[1] = rd_b_idx;

   for (genvar r = 0; r < NUM_RD; r++) begin : g_map
      bankrf_port_map i_map (
         .mode  (mode),
         .name  (rd_name[r]),
         .pidx  (rd_pidx[r]),
         .is_pc (rd_is_pc[r])
      );
      assign port_data[r] = rd_is_pc[r] ? pc_view : gpr_rdata[r];
   end

   bankrf_port_map i_wmap (
      .mode  (mode),
      .name  (wr_idx),
      .pidx  (wr_pidx),
      .is_pc (wr_is_pc)
   );

   assign gpr_we = wr_en && !wr_is_pc;

   bankrf_gpr_array #(
      .DATA_W      (DATA_W),
      .NUM_RD      (NUM_RD),
      .WRITE_FIRST (WRITE_FIRST)
   ) i_gpr (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (gpr_we),
      .wpidx (wr_pidx),
      .wdata (wr_data),
      .rpidx (rd_pidx),
      .rdata (gpr_rdata)
   );

   always_comb begin
      if (wr_en && wr_is_pc) pc_next = wr_data;
      else if (pc_wr_en)     pc_next = pc_wr_data;
      else                   pc_next = pc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= PC_RESET;
      else        pc_q <= pc_next;
   end

   if (WRITE_FIRST) begin : g_pc_fwd
      assign pc_view = pc_next;
   end else begin : g_pc_plain
      assign pc_view = pc_q;
   end

   bankrf_status #(
      .DATA_W     (DATA_W),
      .RESET_MODE (MODE_SUPV)
   ) i_status (
      .clk          (clk),
      .rst_n        (rst_n),
      .stat_wr_en   (stat_wr_en),
      .stat_wr_data (stat_wr_data),
      .sav_rd_en    (sav_rd_en),
      .sav_wr_en    (sav_wr_en),
      .sav_wr_data  (sav_wr_data),
      .exc_en       (exc_en),
      .exc_mode     (exc_mode),
      .stat_q       (stat_q),
      .sav_rd_data  (sav_rd_data),
      .sav_err      (sav_err)
   );

   assign rd_a_data = port_data[0];
   assign rd_b_data = port_data[1];
   assign pc_out    = pc_q;
   assign stat_out  = stat_q;
   assign mode_out  = mode;
endmodule

// File: rtl/bankrf_checker.sv
module bankrf_checker
   import bankrf_pkg::*;
#(
   parameter int unsigned       DATA_W      = 32,
   parameter logic [DATA_W-1:0] PC_RESET    = '0,
   parameter bit                WRITE_FIRST = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        rd_a_idx,
   input logic [DATA_W-1:0] rd_a_data,
   input logic              wr_en,
   input logic [3:0]        wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic              pc_wr_en,
   input logic [DATA_W-1:0] pc_out,
   input logic              stat_wr_en,
   input logic [DATA_W-1:0] stat_wr_data,
   input logic [DATA_W-1:0] stat_out,
   input logic [4:0]        mode_out,
   input logic              sav_rd_en,
   input logic              sav_wr_en,
   input logic [DATA_W-1:0] sav_rd_data,
   input logic              sav_err,
   input logic              exc_en,
   input logic [4:0]        exc_mode
);
   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mode_out == MODE_SUPV && pc_out == PC_RESET));

   // R4: a stored value is visible one cycle later from the same name in the same mode
   assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx != 4'd15) |=>
         (!(rd_a_idx == $past(wr_idx) && mode_out == $past(mode_out)
            && !(wr_en && wr_idx == rd_a_idx)) || rd_a_data == $past(wr_data)));

   assert_pc_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_wr_en && !(wr_en && wr_idx == 4'd15)) |=> $stable(pc_out));

   assert_write_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (WRITE_FIRST && wr_en && rd_a_idx == wr_idx) |-> rd_a_data == wr_data);

   assert_stat_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr_en && !exc_en) |=> stat_out == $past(stat_wr_data));

   assert_no_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !has_saved(mode_out) |-> (sav_rd_data == '0 && sav_err == (sav_rd_en || sav_wr_en)));

   assert_exc_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
      exc_en |=> (mode_out == $past(exc_mode)
                  && stat_out[DATA_W-1:5] == $past(stat_out[DATA_W-1:5])));

   assert_exc_save_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_en && has_saved(exc_mode)) |=> sav_rd_data == $past(stat_out));
endmodule

bind banked_regfile bankrf_checker #(
   .DATA_W      (DATA_W),
   .PC_RESET    (PC_RESET),
   .WRITE_FIRST (WRITE_FIRST)
) i_bankrf_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .rd_a_idx     (rd_a_idx),
   .rd_a_data    (rd_a_data),
   .wr_en        (wr_en),
   .wr_idx       (wr_idx),
   .wr_data      (wr_data),
   .pc_wr_en     (pc_wr_en),
   .pc_out       (pc_out),
   .stat_wr_en   (stat_wr_en),
   .stat_wr_data (stat_wr_data),
   .stat_out     (stat_out),
   .mode_out     (mode_out),
   .sav_rd_en    (sav_rd_en),
   .sav_wr_en    (sav_wr_en),
   .sav_rd_data  (sav_rd_data),
   .sav_err      (sav_err),
   .exc_en       (exc_en),
   .exc_mode     (exc_mode)
);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
   localparam int W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [3:0]   rd_a_idx, rd_b_idx, wr_idx;
   logic [W-1:0] rd_a_data, rd_b_data, wr_data, pc_wr_data, pc_out;
   logic [W-1:0] stat_wr_data, stat_out, sav_wr_data, sav_rd_data;
   logic         wr_en, pc_wr_en, stat_wr_en, sav_rd_en, sav_wr_en, sav_err, exc_en;
   logic [4:0]   mode_out, exc_mode;

   banked_regfile i_banked_regfile (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data), .pc_out(pc_out),
      .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data), .stat_out(stat_out),
      .mode_out(mode_out),
      .sav_rd_en(sav_rd_en), .sav_wr_en(sav_wr_en), .sav_wr_data(sav_wr_data),
      .sav_rd_data(sav_rd_data), .sav_err(sav_err),
      .exc_en(exc_en), .exc_mode(exc_mode)
   );

   int n_checks = 0;
   int n_fail   = 0;

   // Reference state, keyed by owner name rather than by any index layout
   logic [W-1:0] m_gpr [string];
   logic [W-1:0] m_sav [int];
   logic [W-1:0] m_pc, m_stat;

   logic [4:0] codes [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                             5'b10111, 5'b11011, 5'b11111, 5'b00000};

   function automatic string owner(logic [4:0] m, int r);
      if (m == 5'b10001 && r >= 8) return "fast";
      if (r >= 13) begin
         case (m)
            5'b10010: return "irq";
            5'b10011: return "supv";
            5'b10111: return "abort";
            5'b11011: return "undef";
            default: ;
         endcase
      end
      return "user";
   endfunction

   function automatic string key(logic [4:0] m, int r);
      return $sformatf("%s_%0d", owner(m, r), r);
   endfunction

   function automatic bit has_sav(logic [4:0] m);
      return (m == 5'b10001 || m == 5'b10010 || m == 5'b10011 ||
              m == 5'b10111 || m == 5'b11011);
   endfunction

   function automatic logic [W-1:0] exp_read(logic [3:0] r);
      if (r == 4'd15) begin
         if (wr_en && wr_idx == 4'd15) return wr_data;
         if (pc_wr_en) return pc_wr_data;
         return m_pc;
      end
      if (wr_en && wr_idx == r) return wr_data;
      return m_gpr[key(m_stat[4:0], int'(r))];
   endfunction

   task automatic model_reset();
      m_pc   = '0;
      m_stat = 32'h0000_0013;
      m_gpr.delete();
      m_sav.delete();
      foreach (codes[i]) begin
         for (int r = 0; r < 15; r++) m_gpr[key(codes[i], r)] = '0;
         if (has_sav(codes[i])) m_sav[int'(codes[i])] = '0;
      end
   endtask

   task automatic model_update();
      logic [W-1:0] old_stat;
      logic [4:0]   m;
      old_stat = m_stat;
      m = old_stat[4:0];
      if (wr_en) begin
         if (wr_idx == 4'd15) m_pc = wr_data;
         else m_gpr[key(m, int'(wr_idx))] = wr_data;
      end
      if (pc_wr_en && !(wr_en && wr_idx == 4'd15)) m_pc = pc_wr_data;
      if (sav_wr_en && has_sav(m)) m_sav[int'(m)] = sav_wr_data;
      if (exc_en && has_sav(exc_mode)) m_sav[int'(exc_mode)] = old_stat;
      if (exc_en) m_stat = {old_stat[W-1:5], exc_mode};
      else if (stat_wr_en) m_stat = stat_wr_data;
   endtask

   task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic compare_all(string rt, string st);
      logic [4:0] m;
      m = m_stat[4:0];
      chk(rt, "read A", rd_a_data, exp_read(rd_a_idx));
      chk(rt, "read B", rd_b_data, exp_read(rd_b_idx));
      chk("R5", "pc_out", pc_out, m_pc);
      chk(st, "stat_out", stat_out, m_stat);
      chk(st, "mode_out", W'(mode_out), W'(m));
      chk(has_sav(m) ? st : "R9", "sav_rd_data", sav_rd_data,
          has_sav(m) ? m_sav[int'(m)] : '0);
      chk(has_sav(m) ? st : "R9", "sav_err", W'(sav_err),
          W'((sav_rd_en || sav_wr_en) && !has_sav(m)));
   endtask

   task automatic idle();
      wr_en = 0; pc_wr_en = 0; stat_wr_en = 0; sav_rd_en = 0; sav_wr_en = 0; exc_en = 0;
      wr_idx = 0; wr_data = 0; pc_wr_data = 0; stat_wr_data = 0; sav_wr_data = 0;
      exc_mode = 5'b10000; rd_a_idx = 0; rd_b_idx = 0;
   endtask

   // Inputs change at the falling edge; outputs compared 5 ns later
   task automatic step(string rt, string st);
      #5;
      compare_all(rt, st);
      @(posedge clk);
      if (rst_n) model_update();
      @(negedge clk);
   endtask

   task automatic set_mode(logic [4:0] m, logic [26:0] upper);
      idle();
      stat_wr_en = 1; stat_wr_data = {upper, m};
      step("R3", "R7");
      idle();
   endtask

   initial begin
      idle();
      model_reset();
      @(negedge clk);
      // R1: state while held in reset and right after release
      for (int i = 0; i < 3; i++) begin
         rd_a_idx = 4'(i); rd_b_idx = 4'd15;
         step("R1", "R1");
      end
      rst_n = 1'b1;
      rd_a_idx = 4'd13; rd_b_idx = 4'd14;
      step("R1", "R1");

      // R2: write r8 and r13 in every mode, then read both back in every mode
      foreach (codes[i]) begin
         set_mode(codes[i], 27'h0);
         wr_en = 1; wr_idx = 4'd13; wr_data = 32'h1300_0000 + i; rd_a_idx = 4'd13;
         step("R2", "R7");
         wr_idx = 4'd8; wr_data = 32'h0800_0000 + i; rd_a_idx = 4'd13; rd_b_idx = 4'd8;
         step("R2", "R7");
         idle();
      end
      foreach (codes[i]) begin
         set_mode(codes[i], 27'h0);
         rd_a_idx = 4'd13; rd_b_idx = 4'd8;
         step("R2", "R7");
         rd_a_idx = 4'd14; rd_b_idx = 4'd12;
         step("R2", "R7");
      end

      // R4/R5: program counter port, and write port priority on r15
      idle();
      pc_wr_en = 1; pc_wr_data = 32'h0000_1000; rd_b_idx = 4'd15;
      step("R5", "R7");
      idle(); rd_a_idx = 4'd15;
      step("R3", "R7");
      pc_wr_en = 1; pc_wr_data = 32'hDEAD_0000;
      wr_en = 1; wr_idx = 4'd15; wr_data = 32'h0000_2000; rd_a_idx = 4'd15;
      step("R4", "R7");
      idle(); rd_a_idx = 4'd15;
      step("R4", "R7");

      // R6: same-cycle write and read of one register, r15 included
      set_mode(5'b10001, 27'h0);
      wr_en = 1; wr_idx = 4'd9; wr_data = 32'hCAFE_0009; rd_a_idx = 4'd9; rd_b_idx = 4'd9;
      step("R6", "R7");
      wr_idx = 4'd15; wr_data = 32'hCAFE_0F0F; rd_a_idx = 4'd15; rd_b_idx = 4'd3;
      step("R6", "R7");
      idle(); pc_wr_en = 1; pc_wr_data = 32'h0000_3000; rd_b_idx = 4'd15;
      step("R6", "R7");
      idle();

      // R8/R9: saved status in modes with and without a slot
      foreach (codes[i]) begin
         set_mode(codes[i], 27'h0);
         sav_wr_en = 1; sav_wr_data = 32'h5A00_0000 + i;
         step(has_sav(codes[i]) ? "R8" : "R9", has_sav(codes[i]) ? "R8" : "R9");
         idle(); sav_rd_en = 1;
         step(has_sav(codes[i]) ? "R8" : "R9", has_sav(codes[i]) ? "R8" : "R9");
         idle();
         step("R9", "R9");
      end

      // R10: exception entry, alone and against competing writes
      set_mode(5'b10000, 27'h5A5_A5A5);
      exc_en = 1; exc_mode = 5'b10010;
      step("R3", "R10");
      idle(); sav_rd_en = 1;
      step("R3", "R10");
      exc_en = 1; exc_mode = 5'b10011; stat_wr_en = 1; stat_wr_data = 32'hFFFF_FF10;
      step("R3", "R10");
      idle();
      step("R3", "R10");
      exc_en = 1; exc_mode = 5'b10011; sav_wr_en = 1; sav_wr_data = 32'h1234_5678;
      step("R3", "R10");
      idle();
      step("R3", "R10");
      exc_en = 1; exc_mode = 5'b11111;
      step("R3", "R10");
      idle(); sav_rd_en = 1;
      step("R3", "R10");
      exc_en = 1; exc_mode = 5'b11011; wr_en = 1; wr_idx = 4'd13; wr_data = 32'h0000_D13D;
      step("R3", "R10");
      idle(); rd_a_idx = 4'd13;
      step("R3", "R10");

      // R3: mixed random traffic across all modes
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] u;
         u = $urandom;
         rd_a_idx     = 4'($urandom);
         rd_b_idx     = 4'($urandom);
         wr_en        = u[0];
         wr_idx       = (u[9:7] == 0) ? rd_a_idx : 4'($urandom);
         wr_data      = $urandom;
         pc_wr_en     = (u[3:1] == 0);
         pc_wr_data   = $urandom;
         stat_wr_en   = (u[6:4] == 0);
         stat_wr_data = {27'($urandom), codes[u[12:10]]};
         sav_rd_en    = u[13];
         sav_wr_en    = u[15:14] == 0;
         sav_wr_data  = $urandom;
         exc_en       = (u[19:16] == 0);
         exc_mode     = codes[u[22:20]];
         step("R3", "R7");
      end
      idle();
      step("R3", "R7");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule